// File: doc/BRIEF.md
# Synchronous Burst Read Host Interface

This block is the slave side of a synchronous host bus with separate address and data lines. It serves sequential burst reads from an internal 32-bit word memory. The host pulls its active-low select low and pulses an active-low strobe for one clock with the read/write line set to read. The block captures the start address on that edge, waits a fixed number of clocks to cover the memory read latency, and then presents one 32-bit word per clock. An active-low ready flag marks every clock in which the data bus carries a valid word.

The host keeps its active-low last flag high until the word it wants to be final is on the bus. The block then stops driving the bus and raises ready on the next edge, and it waits for select to go high before it accepts a new burst. Two word-enable inputs mask the 16-bit halves of each returned word. A stop output tells the host that an internal command FIFO is full.

The memory is a synchronous read model preloaded with a computed pattern, so returned data can be predicted from the address alone.

Top module: `burst_rd_host_if`

## Requirements
- R1: After reset, `rdy_n` and `stop_n` are 1, `bus_oe` is 0 and `bus_rdata` is 0.
- R2: A burst starts on a clock edge where `host_sel_n`=0, `strb_n`=0 and `rd_wr`=1 (1 means read). `rdy_n` stays 1 for the next START_WAIT (default 2) clocks and goes 0 after edge START_WAIT from the start edge.
- R3: The first word is the one at the start address captured on the start edge. Each later clock during the burst delivers the word at the next address, and the address wraps from 2**AW-1 to 0.
- R4: `word_en[1]` enables bits 31:16 and `word_en[0]` enables bits 15:0 of the returned word. An enable at 0 forces its half to 0x0000.
- R5: On the edge after `last_n` is sampled 0 while `rdy_n` is 0, `rdy_n` returns to 1 and `bus_oe` to 0. While `host_sel_n` stays 0 after that, no further burst starts, even if the strobe pulses again.
- R6: `host_sel_n` sampled 1 on any edge ends the burst: `rdy_n` is 1 after that edge, and a later strobe starts a new burst normally.
- R7: A strobe with `rd_wr`=0, or a strobe while `host_sel_n`=1, does not start a burst.
- R8: `stop_n` equals the inverse of `fifo_full` as sampled on the previous clock edge.
- R9: `bus_oe` is 1 exactly when `rdy_n` is 0. While `bus_oe` is 0, `bus_rdata` is 0.
- R10: The memory word at address a (a zero-extended to 16 bits) is {a XOR 0xC3A5, a + 0x0101}, upper half first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Active-low chip select, held low for the whole burst |
| strb_n | input | 1 | Active-low one-clock start strobe |
| rd_wr | input | 1 | 1 selects read; a write-selected strobe is ignored |
| addr | input | AW | Start word address, captured on the start edge |
| word_en | input | 2 | Per-half enables: bit 1 upper half, bit 0 lower half |
| last_n | input | 1 | Active-low flag marking the final word of the burst |
| fifo_full | input | 1 | Internal command FIFO full status |
| rdy_n | output | 1 | Active-low: valid word on the data bus this clock |
| stop_n | output | 1 | Active-low: command FIFO is full |
| bus_oe | output | 1 | Data bus drive enable; the bus is released when 0 |
| bus_rdata | output | 32 | Read data word |

## Verification
The bench builds the block with AW=4, so the memory holds only sixteen words. This lets a five-word burst starting at address 14 cross the wrap from 15 to 0 and check it word by word. START_WAIT stays at its default of 2, so the bench counts exactly two idle clocks before the first word. The table bursts vary the start address, the length (down to a single word) and all four word-enable patterns.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned HW = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_HOLD = 2'd3
    } bst_state_e;

    typedef struct packed {
        logic load;
        logic advance;
        logic xfer;
    } bst_ctl_t;

    function automatic logic [DW-1:0] seed_word(input logic [HW-1:0] a);
        return {a ^ 16'hC3A5, a + 16'h0101};
    endfunction

    function automatic logic [DW-1:0] half_mask(input logic [1:0] en,
                                                input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r[DW-1:HW] = en[1] ? d[DW-1:HW] : '0;
        r[HW-1:0]  = en[0] ? d[HW-1:0]  : '0;
        return r;
    endfunction

endpackage

// File: rtl/burst_rd_fsm.sv
module burst_rd_fsm
    import burst_rd_pkg::*;
#(
    parameter int unsigned START_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       strb_n,
    input  logic       rd_wr,
    input  logic       last_n,
    output bst_state_e state,
    output bst_ctl_t   ctl
);

    localparam int unsigned WCW = $clog2(START_WAIT) + 1;
    localparam logic [WCW-1:0] WLAST = WCW'(START_WAIT - 1);

    bst_state_e       state_q, state_d;
    logic [WCW-1:0]   wcnt_q, wcnt_d;

    always_comb begin
        state_d     = state_q;
        wcnt_d      = wcnt_q;
        ctl.load    = 1'b0;
        ctl.advance = 1'b0;
        ctl.xfer    = (state_q == ST_XFER);
        unique case (state_q)
            ST_IDLE: begin
                if (!sel_n && !strb_n && rd_wr) begin
                    state_d  = ST_WAIT;
                    wcnt_d   = '0;
                    ctl.load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (sel_n)                 state_d = ST_IDLE;
                else if (wcnt_q == WLAST)  state_d = ST_XFER;
                else                       wcnt_d  = wcnt_q + 1'b1;
            end
            ST_XFER: begin
                if (sel_n)        state_d = ST_IDLE;
                else if (!last_n) state_d = ST_HOLD;
                else              ctl.advance = 1'b1;
            end
            ST_HOLD: begin
                if (sel_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/burst_rd_addr_ctr.sv
module burst_rd_addr_ctr #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] rd_addr
);

    logic [AW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (load)         cnt_d = start_addr;
        else if (advance) cnt_d = cnt_q + 1'b1;
        else              cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // lookahead: memory reads the address that holds after this edge
    assign rd_addr = cnt_d;

endmodule

// File: rtl/burst_rd_mem.sv
module burst_rd_mem
    import burst_rd_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = seed_word(HW'(i));
        end
    end

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/burst_rd_host_if.sv
module burst_rd_host_if
    import burst_rd_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned START_WAIT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_sel_n,
    input  logic          strb_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    word_en,
    input  logic          last_n,
    input  logic          fifo_full,
    output logic          rdy_n,
    output logic          stop_n,
    output logic          bus_oe,
    output logic [31:0]   bus_rdata
);

    bst_state_e    state;
    bst_ctl_t      ctl;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] mem_q;
    logic          stop_q;

    burst_rd_fsm #(.START_WAIT(START_WAIT)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (host_sel_n),
        .strb_n (strb_n),
        .rd_wr  (rd_wr),
        .last_n (last_n),
        .state  (state),
        .ctl    (ctl)
    );

    burst_rd_addr_ctr #(.AW(AW)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .load       (ctl.load),
        .advance    (ctl.advance),
        .start_addr (addr),
        .rd_addr    (rd_addr)
    );

    burst_rd_mem #(.AW(AW)) u_mem (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) stop_q <= 1'b0;
        else     stop_q <= fifo_full;
    end

    assign bus_oe    = ctl.xfer;
    assign rdy_n     = ~ctl.xfer;
    assign stop_n    = ~stop_q;
    assign bus_rdata = ctl.xfer ? half_mask(word_en, mem_q) : '0;

endmodule

// File: rtl/burst_rd_host_if_chk.sv
module burst_rd_host_if_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          host_sel_n,
    input logic          last_n,
    input logic [1:0]    word_en,
    input logic          fifo_full,
    input logic          rdy_n,
    input logic          stop_n,
    input logic          bus_oe,
    input logic [31:0]   bus_rdata
);

    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        host_sel_n |=> rdy_n);

    p_last_r5: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !last_n) |=> rdy_n);

    p_stop_set_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_full |=> !stop_n);

    p_stop_clr_r8: assert property (@(posedge clk) disable iff (rst)
        !fifo_full |=> stop_n);

    p_wait_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> $past(rdy_n, 2));

    p_mask_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !word_en[1]) |-> (bus_rdata[31:16] == 16'h0000));

    p_mask_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !word_en[0]) |-> (bus_rdata[15:0] == 16'h0000));

    p_idle_bus_r9: assert property (@(posedge clk) disable iff (rst)
        rdy_n |-> (!bus_oe && bus_rdata == 32'h0));

endmodule

bind burst_rd_host_if burst_rd_host_if_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel_n (host_sel_n),
    .last_n     (last_n),
    .word_en    (word_en),
    .fifo_full  (fifo_full),
    .rdy_n      (rdy_n),
    .stop_n     (stop_n),
    .bus_oe     (bus_oe),
    .bus_rdata  (bus_rdata)
);

// File: tb/burst_rd_host_if_test.sv
module burst_rd_host_if_test;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 6;

    // vector: {start addr[3:0], length[4:0], word_en[1:0]}
    localparam logic [10:0] VEC [NVEC] = '{
        {4'd0,  5'd4, 2'b11},
        {4'd3,  5'd1, 2'b11},
        {4'd7,  5'd3, 2'b01},
        {4'd9,  5'd2, 2'b10},
        {4'd14, 5'd5, 2'b11},
        {4'd5,  5'd3, 2'b00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_sel_n = 1'b1;
    logic          strb_n = 1'b1;
    logic          rd_wr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    word_en = 2'b11;
    logic          last_n = 1'b1;
    logic          fifo_full = 1'b0;
    logic          rdy_n, stop_n, bus_oe;
    logic [31:0]   bus_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    burst_rd_host_if #(.AW(AW), .START_WAIT(2)) uut (
        .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .strb_n(strb_n),
        .rd_wr(rd_wr), .addr(addr), .word_en(word_en), .last_n(last_n),
        .fifo_full(fifo_full), .rdy_n(rdy_n), .stop_n(stop_n),
        .bus_oe(bus_oe), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] exp_word(input int a, input logic [1:0] en);
        logic [15:0] a16;
        logic [31:0] w;
        a16 = 16'(a % DEPTH);
        w = {a16 ^ 16'hC3A5, a16 + 16'h0101};
        if (!en[1]) w[31:16] = 16'h0;
        if (!en[0]) w[15:0]  = 16'h0;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_idle(input string req);
        chk(req, {30'd0, rdy_n, bus_oe}, {30'd0, 1'b1, 1'b0});
        chk(req, bus_rdata, 32'h0);
    endtask

    // start a read burst and check every word; sel stays low afterwards
    task automatic burst(input int a, input int len, input logic [1:0] en);
        host_sel_n = 1'b0; strb_n = 1'b0; rd_wr = 1'b1;
        addr = AW'(a); word_en = en; last_n = 1'b1;
        cyc(1);
        strb_n = 1'b1;
        chk("R2 wait1", {31'd0, rdy_n}, 32'd1);
        cyc(1);
        chk("R2 wait2", {31'd0, rdy_n}, 32'd1);
        cyc(1);
        for (int i = 0; i < len; i++) begin
            chk("R2/R9 ready", {30'd0, rdy_n, bus_oe}, 32'b01);
            chk("R3/R4/R10 data", bus_rdata, exp_word(a + i, en));
            if (i == len - 1) last_n = 1'b0;
            cyc(1);
        end
        last_n = 1'b1;
        chk_idle("R5 after last");
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk_idle("R1 reset");
        chk("R1 stop", {31'd0, stop_n}, 32'd1);

        for (int v = 0; v < NVEC; v++) begin
            burst(int'(VEC[v][10:7]), int'(VEC[v][6:2]), VEC[v][1:0]);
            host_sel_n = 1'b1;
            cyc(1);
        end

        // R5: strobe during hold is ignored
        burst(2, 2, 2'b11);
        strb_n = 1'b0; cyc(1); strb_n = 1'b1;
        cyc(3);
        chk_idle("R5 hold strobe");
        host_sel_n = 1'b1; cyc(1);

        // R7: write-selected strobe ignored
        host_sel_n = 1'b0; strb_n = 1'b0; rd_wr = 1'b0; addr = 4'd1;
        cyc(1); strb_n = 1'b1; rd_wr = 1'b1;
        cyc(3);
        chk_idle("R7 write strobe");
        host_sel_n = 1'b1; cyc(1);

        // R7: strobe without select ignored
        strb_n = 1'b0; cyc(1); strb_n = 1'b1;
        cyc(3);
        chk_idle("R7 no select");

        // R6: abort in the middle of the data phase
        host_sel_n = 1'b0; strb_n = 1'b0; addr = 4'd6; word_en = 2'b11;
        cyc(1); strb_n = 1'b1; cyc(2);
        chk("R6 first word", bus_rdata, exp_word(6, 2'b11));
        cyc(1);
        host_sel_n = 1'b1;
        cyc(1);
        chk_idle("R6 abort data");
        cyc(2);
        chk_idle("R6 stays idle");

        // R6: abort during the wait phase
        host_sel_n = 1'b0; strb_n = 1'b0; addr = 4'd8;
        cyc(1); strb_n = 1'b1; host_sel_n = 1'b1;
        cyc(3);
        chk_idle("R6 abort wait");

        // R6: new burst after abort works normally
        burst(11, 2, 2'b11);
        host_sel_n = 1'b1; cyc(1);

        // R8: stop follows fifo_full one clock later
        fifo_full = 1'b1;
        chk("R8 before edge", {31'd0, stop_n}, 32'd1);
        cyc(1);
        chk("R8 full", {31'd0, stop_n}, 32'd0);
        fifo_full = 1'b0;
        cyc(1);
        chk("R8 clear", {31'd0, stop_n}, 32'd1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule